// File: doc/BRIEF.md
# Dual-Clock Word FIFO with Almost-Full and Almost-Empty Flags

This block is a 64-deep, 36-bit-wide first-in first-out buffer between two unrelated clock domains. The producer side presents a word and a write enable on its own clock. The consumer side pulls words with a read enable on a second clock and sees each one in a registered output. The two clocks may be fully asynchronous, or they may share edges. The read and write pointers cross between the domains as gray code through two flip-flops. Each status flag is computed in the domain of the port that uses it: full and almost-full on the write clock, empty and almost-empty on the read clock.

A two-bit select input fixes the almost-flag threshold X. It is captured only while the block is held in reset. The asynchronous active-low reset only takes effect after it has been seen low on four consecutive rising edges of each clock. A shorter glitch is therefore harmless.

Top module: `xclk_fifo`

## Requirements
- R1: After `rst_n` is held low for at least four rising edges of both `wclk` and `rclk` and then released, the FIFO holds no words: `empty`=1, `aempty`=1, `full`=0, `afull`=0 and `rd_data`=0.
- R2: A low pulse on `rst_n` that spans at most two rising edges of either clock has no effect: the stored words, their order and all flags are kept.
- R3: Words leave in the order they were written, all 36 bits intact; `rd_data` updates on the `rclk` edge that accepts a read.
- R4: A write presented while `full`=1 is ignored, and no word is stored.
- R5: A read presented while `empty`=1 is ignored: `rd_data` keeps its value and the read pointer does not move.
- R6: After a write into an empty FIFO, `empty` is still 1 after the first following rising `rclk` edge and becomes 0 after the second.
- R7: `full` rises on the `wclk` edge that stores the 64th word. After one read from a full FIFO, `full` is still 1 after the first following rising `wclk` edge and is 0 after the second.
- R8: Once the pointers have settled, `aempty`=1 exactly when the stored count is less than or equal to X.
- R9: Once the pointers have settled, `afull`=1 exactly when the stored count is greater than or equal to 64 minus X.
- R10: X is taken from `ofs_sel` during reset, with 2'b00 giving 16, 2'b01 giving 12, 2'b10 giving 8 and 2'b11 giving 4. Changing `ofs_sel` after reset has no effect.
- R11: With both enables active at once and each gated only by its own flag, every word is delivered once, in order, with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, must be held over four edges of each clock |
| ofs_sel | input | 2 | Almost-flag threshold select, captured during reset |
| wr_en | input | 1 | Write request, taken on a rising `wclk` edge |
| wr_data | input | 36 | Word to store |
| rd_en | input | 1 | Read request, taken on a rising `rclk` edge |
| rd_data | output | 36 | Registered word from the last accepted read |
| full | output | 1 | 64 words stored (write domain) |
| afull | output | 1 | Count at least 64 minus X (write domain) |
| empty | output | 1 | No readable word (read domain) |
| aempty | output | 1 | Count at most X (read domain) |

## Verification
The case that matters most is a write and a read taking effect in the same stretch of time, while each side sees the other's pointer only after synchronization delay. This is provoked by preloading a few words and then running a producer thread and a consumer thread concurrently. Each keeps its enable high whenever its own flag allows. The order and content of every delivered word is judged against a queue model. A second overlap, a read that frees space while the write side still reports full, is judged by counting `wclk` edges until `full` drops.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

    // Threshold select codes, captured only while the block is in reset.
    typedef enum logic [1:0] {
        OFS_QUARTER = 2'b00,
        OFS_3_16TH  = 2'b01,
        OFS_EIGHTH  = 2'b10,
        OFS_16TH    = 2'b11
    } ofs_sel_e;

    // Almost-flag offset: depth/4 minus depth/16 per select step.
    function automatic int unsigned flag_offset(input int unsigned depth,
                                                input logic [1:0] sel);
        return (depth / 4) - (depth / 16) * 32'(sel);
    endfunction

endpackage

// File: rtl/xfifo_rst_gate.sv
module xfifo_rst_gate #(
    parameter int unsigned HOLD_EDGES = 4
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_o
);
    localparam int unsigned CW = $clog2(HOLD_EDGES + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [CW-1:0] cnt;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d    = gate_q;
        gate_d.s1 = arst_n;
        gate_d.s2 = gate_q.s1;
        if (gate_q.s2)
            gate_d.cnt = '0;
        else if (gate_q.cnt != CW'(HOLD_EDGES))
            gate_d.cnt = gate_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) gate_q <= gate_d;

    assign rst_o = (gate_q.cnt == CW'(HOLD_EDGES));
endmodule

// File: rtl/xfifo_gray_sync.sv
module xfifo_gray_sync #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = d_i;
        sync_d.s2 = sync_q.s1;
        if (rst) sync_d = '0;
    end

    always_ff @(posedge clk) sync_q <= sync_d;

    assign q_o = sync_q.s2;
endmodule

// File: rtl/xfifo_wr_ctl.sv
module xfifo_wr_ctl #(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic [1:0]    sel_i,
    input  logic [AW:0]   rgray_i,
    output logic          fire_o,
    output logic [AW-1:0] addr_o,
    output logic [AW:0]   bin_o,
    output logic [AW:0]   gray_o,
    output logic          full_o,
    output logic          afull_o
);
    localparam int unsigned PW    = AW + 1;
    localparam int unsigned DEPTH = 1 << AW;

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic [PW-1:0] ofs;
    } wst_t;

    wst_t          wst_d, wst_q;
    logic [PW-1:0] rbin;
    logic [PW-1:0] used;

    always_comb begin
        rbin[PW-1] = rgray_i[PW-1];
        for (int i = PW - 2; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_i[i];
        used    = wst_q.ptr - rbin;
        full_o  = (used == PW'(DEPTH));
        afull_o = (used >= (PW'(DEPTH) - wst_q.ofs));
        fire_o  = en_i && !full_o;

        wst_d = wst_q;
        if (fire_o) wst_d.ptr = wst_q.ptr + 1'b1;
        wst_d.gray = wst_d.ptr ^ (wst_d.ptr >> 1);
        if (rst) begin
            wst_d.ptr  = '0;
            wst_d.gray = '0;
            wst_d.ofs  = PW'(xfifo_pkg::flag_offset(DEPTH, sel_i));
        end
    end

    always_ff @(posedge clk) wst_q <= wst_d;

    assign addr_o = wst_q.ptr[AW-1:0];
    assign bin_o  = wst_q.ptr;
    assign gray_o = wst_q.gray;
endmodule

// File: rtl/xfifo_rd_ctl.sv
module xfifo_rd_ctl #(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic [1:0]    sel_i,
    input  logic [AW:0]   wgray_i,
    output logic          fire_o,
    output logic [AW-1:0] addr_o,
    output logic [AW:0]   bin_o,
    output logic [AW:0]   gray_o,
    output logic          empty_o,
    output logic          aempty_o
);
    localparam int unsigned PW    = AW + 1;
    localparam int unsigned DEPTH = 1 << AW;

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic [PW-1:0] ofs;
    } rst_t;

    rst_t          rs_d, rs_q;
    logic [PW-1:0] wbin;
    logic [PW-1:0] used;

    always_comb begin
        wbin[PW-1] = wgray_i[PW-1];
        for (int i = PW - 2; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_i[i];
        used     = wbin - rs_q.ptr;
        empty_o  = (used == '0);
        aempty_o = (used <= rs_q.ofs);
        fire_o   = en_i && !empty_o;

        rs_d = rs_q;
        if (fire_o) rs_d.ptr = rs_q.ptr + 1'b1;
        rs_d.gray = rs_d.ptr ^ (rs_d.ptr >> 1);
        if (rst) begin
            rs_d.ptr  = '0;
            rs_d.gray = '0;
            rs_d.ofs  = PW'(xfifo_pkg::flag_offset(DEPTH, sel_i));
        end
    end

    always_ff @(posedge clk) rs_q <= rs_d;

    assign addr_o = rs_q.ptr[AW-1:0];
    assign bin_o  = rs_q.ptr;
    assign gray_o = rs_q.gray;
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
    parameter int unsigned AW        = 6,
    parameter int unsigned DW        = 36,
    parameter int unsigned RST_EDGES = 4
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic [1:0]    ofs_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          full,
    output logic          afull,
    output logic          empty,
    output logic          aempty
);
    localparam int unsigned DEPTH = 1 << AW;
    localparam int unsigned PW    = AW + 1;

    logic          wrst, rrst;
    logic          w_fire, r_fire;
    logic [AW-1:0] w_addr, r_addr;
    logic [PW-1:0] w_ptr, r_ptr, w_gray, r_gray;
    logic [PW-1:0] w_gray_sync, r_gray_sync;
    logic [DW-1:0] rdat_d, rdat_q;
    logic [DW-1:0] mem [DEPTH];

    xfifo_rst_gate #(.HOLD_EDGES(RST_EDGES)) u_wgate (
        .clk(wclk), .arst_n(rst_n), .rst_o(wrst));
    xfifo_rst_gate #(.HOLD_EDGES(RST_EDGES)) u_rgate (
        .clk(rclk), .arst_n(rst_n), .rst_o(rrst));

    xfifo_gray_sync #(.W(PW)) u_r2w (
        .clk(wclk), .rst(wrst), .d_i(r_gray), .q_o(r_gray_sync));
    xfifo_gray_sync #(.W(PW)) u_w2r (
        .clk(rclk), .rst(rrst), .d_i(w_gray), .q_o(w_gray_sync));

    xfifo_wr_ctl #(.AW(AW)) u_wr (
        .clk(wclk), .rst(wrst), .en_i(wr_en), .sel_i(ofs_sel),
        .rgray_i(r_gray_sync), .fire_o(w_fire), .addr_o(w_addr),
        .bin_o(w_ptr), .gray_o(w_gray), .full_o(full), .afull_o(afull));

    xfifo_rd_ctl #(.AW(AW)) u_rd (
        .clk(rclk), .rst(rrst), .en_i(rd_en), .sel_i(ofs_sel),
        .wgray_i(w_gray_sync), .fire_o(r_fire), .addr_o(r_addr),
        .bin_o(r_ptr), .gray_o(r_gray), .empty_o(empty), .aempty_o(aempty));

    always_ff @(posedge wclk) begin
        if (w_fire) mem[w_addr] <= wr_data;
    end

    always_comb begin
        rdat_d = rdat_q;
        if (r_fire) rdat_d = mem[r_addr];
        if (rrst) rdat_d = '0;
    end

    always_ff @(posedge rclk) rdat_q <= rdat_d;

    assign rd_data = rdat_q;
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 36
) (
    input logic          wclk,
    input logic          rclk,
    input logic          wrst,
    input logic          rrst,
    input logic          wr_en,
    input logic          rd_en,
    input logic          full,
    input logic          afull,
    input logic          empty,
    input logic          aempty,
    input logic [DW-1:0] rd_data,
    input logic [AW:0]   w_ptr,
    input logic [AW:0]   r_ptr,
    input logic [AW:0]   w_gray_sync
);
    // R1
    rst_rd_side_chk: assert property (@(posedge rclk)
        rrst |=> (empty && aempty && rd_data == '0));

    // R1
    rst_wr_side_chk: assert property (@(posedge wclk)
        wrst |=> (!full && !afull));

    // R4
    no_overflow_chk: assert property (@(posedge wclk) disable iff (wrst)
        (full && wr_en) |=> $stable(w_ptr));

    // R5
    no_underflow_chk: assert property (@(posedge rclk) disable iff (rrst)
        (empty && rd_en) |=> ($stable(rd_data) && $stable(r_ptr)));

    // R6
    empty_clear_src_chk: assert property (@(posedge rclk) disable iff (rrst)
        $fell(empty) |-> !$stable(w_gray_sync));

    // R7
    full_rise_src_chk: assert property (@(posedge wclk) disable iff (wrst)
        $rose(full) |-> $past(wr_en));

    // R8
    empty_in_aempty_chk: assert property (@(posedge rclk) disable iff (rrst)
        empty |-> aempty);

    // R9
    full_in_afull_chk: assert property (@(posedge wclk) disable iff (wrst)
        full |-> afull);
endmodule

bind xclk_fifo xclk_fifo_chk #(.AW(AW), .DW(DW)) u_chk (
    .wclk(wclk), .rclk(rclk), .wrst(wrst), .rrst(rrst),
    .wr_en(wr_en), .rd_en(rd_en), .full(full), .afull(afull),
    .empty(empty), .aempty(aempty), .rd_data(rd_data),
    .w_ptr(w_ptr), .r_ptr(r_ptr), .w_gray_sync(w_gray_sync));

// File: tb/xclk_fifo_bench.sv
module xclk_fifo_bench;
    localparam int WCLK_PERIOD = 10;
    localparam int RCLK_PERIOD = 16;
    localparam int DEPTH       = 64;

    logic        wclk = 1'b0, rclk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ofs_sel = 2'b00;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic [35:0] rd_data;
    logic        full, afull, empty, aempty;

    int n_cmp = 0, n_bad = 0, seq = 0;
    logic [35:0] model[$];

    always #(WCLK_PERIOD / 2) wclk = ~wclk;
    always #(RCLK_PERIOD / 2) rclk = ~rclk;

    xclk_fifo u_xclk_fifo (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .ofs_sel(ofs_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .full(full), .afull(afull), .empty(empty), .aempty(aempty));

    task automatic chk(input bit ok, input string req, input logic [35:0] act,
                       input logic [35:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    function automatic logic [35:0] pat(input int s);
        logic [31:0] m;
        m = (32'(s) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
        return {4'(s), m};
    endfunction

    task automatic do_reset(input logic [1:0] s);
        ofs_sel = s;
        rst_n   = 1'b0;
        repeat (6) @(posedge rclk);
        rst_n = 1'b1;
        repeat (5) @(posedge rclk);
        repeat (2) @(posedge wclk);
        #1;
        model.delete();
    endtask

    task automatic settle();
        repeat (3) @(posedge rclk);
        repeat (3) @(posedge wclk);
        #1;
    endtask

    task automatic wr1(input bit accept);
        logic [35:0] d;
        d = pat(seq);
        seq++;
        @(negedge wclk);
        wr_en   = 1'b1;
        wr_data = d;
        @(posedge wclk);
        #1;
        wr_en = 1'b0;
        if (accept) model.push_back(d);
    endtask

    task automatic rd1(input bit valid, input string req);
        logic [35:0] prev, exp;
        prev = rd_data;
        @(negedge rclk);
        rd_en = 1'b1;
        @(posedge rclk);
        #1;
        rd_en = 1'b0;
        if (valid) begin
            exp = model.pop_front();
            chk(rd_data == exp, req, rd_data, exp);
        end else begin
            chk(rd_data == prev, req, rd_data, prev);
        end
    endtask

    task automatic chk_level(input int n, input int x);
        chk(empty == (n == 0), "R3 empty level", 36'(empty), 36'(n == 0));
        chk(full == (n == DEPTH), "R7 full level", 36'(full), 36'(n == DEPTH));
        chk(aempty == (n <= x), "R8 R10 aempty", 36'(aempty), 36'(n <= x));
        chk(afull == (n >= DEPTH - x), "R9 R10 afull", 36'(afull), 36'(n >= DEPTH - x));
    endtask

    initial begin
        #(WCLK_PERIOD * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        // R1: reset state
        do_reset(2'b00);
        chk(empty == 1'b1, "R1 empty", 36'(empty), 36'd1);
        chk(aempty == 1'b1, "R1 aempty", 36'(aempty), 36'd1);
        chk(full == 1'b0, "R1 full", 36'(full), 36'd0);
        chk(afull == 1'b0, "R1 afull", 36'(afull), 36'd0);
        chk(rd_data == '0, "R1 rd_data", rd_data, 36'd0);

        // R6: empty clears on the second read-clock edge after a write
        wr1(1'b1);
        @(posedge rclk); #1;
        chk(empty == 1'b1, "R6 first edge", 36'(empty), 36'd1);
        @(posedge rclk); #1;
        chk(empty == 1'b0, "R6 second edge", 36'(empty), 36'd0);
        rd1(1'b1, "R3 first word");
        settle();

        // R5: read while empty is ignored
        rd1(1'b0, "R5 data held");
        chk(empty == 1'b1, "R5 still empty", 36'(empty), 36'd1);
        wr1(1'b1);
        settle();
        rd1(1'b1, "R5 pointer unmoved");
        settle();

        // R8 R9 R10: sweep every fill level for each threshold select
        for (int s = 0; s < 4; s++) begin
            int x;
            do_reset(2'(s));
            x = 16 - 4 * s;
            ofs_sel = 2'(s) ^ 2'b11;  // R10: late change must not matter
            for (int n = 0; n <= DEPTH; n++) begin
                settle();
                chk_level(n, x);
                if (n < DEPTH) wr1(1'b1);
            end
            // R4: write while full is dropped
            wr1(1'b0);
            settle();
            chk(full == 1'b1, "R4 still full", 36'(full), 36'd1);
            for (int n = DEPTH; n > 0; n--) begin
                rd1(1'b1, "R3 R4 drain order");
                settle();
                chk_level(n - 1, x);
            end
        end

        // R7: full timing on the way in and on the way out
        do_reset(2'b00);
        for (int n = 0; n < DEPTH - 1; n++) wr1(1'b1);
        chk(full == 1'b0, "R7 63 words", 36'(full), 36'd0);
        wr1(1'b1);
        chk(full == 1'b1, "R7 64th word", 36'(full), 36'd1);
        settle();
        rd1(1'b1, "R3 from full");
        @(posedge wclk); #1;
        chk(full == 1'b1, "R7 first wclk edge", 36'(full), 36'd1);
        @(posedge wclk); #1;
        chk(full == 1'b0, "R7 second wclk edge", 36'(full), 36'd0);
        settle();

        // R2: a short reset glitch leaves contents alone
        rst_n = 1'b0;
        #15;
        rst_n = 1'b1;
        settle();
        settle();
        chk(empty == 1'b0, "R2 empty kept", 36'(empty), 36'd0);
        chk(afull == 1'b1, "R2 afull kept", 36'(afull), 36'd1);
        for (int n = 0; n < DEPTH - 1; n++) rd1(1'b1, "R2 data kept");
        settle();
        chk(empty == 1'b1, "R2 drained", 36'(empty), 36'd1);

        // R11: concurrent producer and consumer
        do_reset(2'b01);
        for (int n = 0; n < 10; n++) wr1(1'b1);
        fork
            begin
                int w;
                w = 0;
                while (w < 150) begin
                    @(negedge wclk);
                    wr_en = !full;
                    if (!full) begin
                        wr_data = pat(seq);
                        model.push_back(pat(seq));
                        seq++;
                        w++;
                    end
                    @(posedge wclk);
                end
                #1;
                wr_en = 1'b0;
            end
            begin
                int r;
                bit en;
                logic [35:0] exp;
                r = 0;
                while (r < 160) begin
                    @(negedge rclk);
                    en    = !empty;
                    rd_en = en;
                    @(posedge rclk);
                    #1;
                    if (en) begin
                        exp = model.pop_front();
                        chk(rd_data == exp, "R11 stream", rd_data, exp);
                        r++;
                    end
                end
                rd_en = 1'b0;
            end
        join
        settle();
        chk(empty == 1'b1, "R11 empty at end", 36'(empty), 36'd1);
        chk(full == 1'b0, "R11 not full at end", 36'(full), 36'd0);

        report();
    end
endmodule